// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame should be kept, based only on its 48-bit destination address. The receive path presents the address with a one-cycle valid strobe, together with the current configuration: the station address split over two words, a 64-bin multicast hash table split over two words, and a control word that carries four mode bits. One cycle later the block produces a registered result: an accept decision and three classification flags (multicast, broadcast, filter fail). The result holds until the next strobe.

Unicast destinations pass only on an exact match with the station address. Broadcast passes unless broadcast is disabled. Other multicast destinations pass when pass-all-multicast is set, or when hash mode is on and the hash table bit chosen by the address CRC is set. Promiscuous mode accepts every frame but leaves the filter-fail flag showing what the address rules alone decided. The CRC-32 used for the hash is computed inside the block.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is asserted and after its release, before any strobe, `res_valid`, `res_accept`, `res_mcast`, `res_bcast` and `res_fail` are all 0.
- R2: A result appears on the first rising edge after `da_valid` is sampled high: `res_valid` is high for exactly that one cycle per strobe, back-to-back strobes give back-to-back results, and the other outputs stay unchanged while no strobe arrives.
- R3: Address byte 0 is `da[7:0]` (first on the wire) up to byte 5 in `da[47:40]`. The station address is `{sta_hi[15:8], sta_hi[7:0], sta_lo[31:24], sta_lo[23:16], sta_lo[15:8], sta_lo[7:0]}` for bytes 5 down to 0; a unicast address (`da[0]`=0) is accepted only when all 48 bits equal it.
- R4: The all-ones address sets `res_bcast` and is accepted unless control bit 11 (broadcast reject) is 1.
- R5: `res_mcast` is 1 when `da[0]` is 1 and the address is not all-ones; broadcast never sets `res_mcast` and is never a hash or pass-all-multicast candidate.
- R6: The hash index is bits 31:26 of a CRC-32 (polynomial 0x04C11DB7, register preset to all ones, no final inversion) shifted most significant bit out first, fed with address bits from byte 0 to byte 5, each byte least significant bit first. Index values 0 to 31 select `hash_lo[index]`, 32 to 63 select `hash_hi[index-32]`. With control bit 13 (hash mode) set, a multicast address whose selected bit is 1 is accepted.
- R7: A multicast address whose selected hash bit is 0, or any multicast address while hash mode is off, is rejected unless pass-all-multicast or promiscuous is set.
- R8: Control bit 19 (pass all multicast) accepts every multicast address regardless of the hash table.
- R9: Control bit 18 (promiscuous) makes `res_accept` 1 for every address, including a broadcast under broadcast reject.
- R10: `res_fail` is 1 exactly when the address rules of R3 to R8, ignoring promiscuous mode, reject the frame; outside promiscuous mode `res_accept` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| da_valid | input | 1 | Destination address strobe, one cycle per frame |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| sta_hi | input | 32 | Station address bytes 5 and 4 in bits 15:0 |
| sta_lo | input | 32 | Station address bytes 3 to 0 |
| hash_hi | input | 32 | Hash table bins 63 to 32 |
| hash_lo | input | 32 | Hash table bins 31 to 0 |
| ctrl | input | 32 | Control word; bits 11, 13, 18, 19 used |
| res_valid | output | 1 | One-cycle pulse when a new result is presented |
| res_accept | output | 1 | Frame is to be kept |
| res_mcast | output | 1 | Destination is multicast (not broadcast) |
| res_bcast | output | 1 | Destination is broadcast |
| res_fail | output | 1 | Address rules rejected the frame |

## Verification
The interesting collision is promiscuous acceptance meeting an address-rule rejection in the same result: a broadcast under broadcast reject, or a missing unicast, with promiscuous set must give `res_accept`=1 and `res_fail`=1 together. The vector table provokes both cases, plus broadcast with pass-all-multicast and broadcast reject set at once, where the broadcast rule must win over the multicast override. Hash bins are probed on both table halves with the target bit alone set and then with every other bit set, and expected indices come from a reflected CRC computed in the bench.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int ADDR_W   = 48;
  localparam int WORD_W   = 32;
  localparam int HASH_W   = 6;
  localparam int TABLE_N  = 1 << HASH_W;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  localparam int CTRL_DISBC  = 11;
  localparam int CTRL_HASH   = 13;
  localparam int CTRL_PROMIS = 18;
  localparam int CTRL_ALLMC  = 19;

  typedef struct packed {
    logic accept;
    logic mcast;
    logic bcast;
    logic fail;
  } rxaf_result_t;

  function automatic logic [31:0] crc_over_addr(input logic [ADDR_W-1:0] a);
    logic [31:0] c;
    logic fb;
    c = '1;
    for (int i = 0; i < ADDR_W; i++) begin
      fb = c[31] ^ a[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/rxaf_hash.sv
module rxaf_hash
  import rxaf_pkg::*;
(
  input  logic [ADDR_W-1:0] da,
  input  logic [WORD_W-1:0] tbl_hi,
  input  logic [WORD_W-1:0] tbl_lo,
  output logic [HASH_W-1:0] idx,
  output logic              hit
);
  logic [31:0]        crc;
  logic [TABLE_N-1:0] tbl;

  always_comb begin
    crc = crc_over_addr(da);
    idx = crc[31 -: HASH_W];
    tbl = {tbl_hi, tbl_lo};
    hit = tbl[idx];
  end
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
  import rxaf_pkg::*;
(
  input  logic [ADDR_W-1:0] da,
  input  logic [WORD_W-1:0] sta_hi,
  input  logic [WORD_W-1:0] sta_lo,
  input  logic [WORD_W-1:0] ctrl,
  input  logic              hash_hit,
  output rxaf_result_t      res
);
  localparam int HI_BYTES = (ADDR_W - WORD_W);

  logic [ADDR_W-1:0] station;
  logic is_bc, is_mc, is_uc, rule_ok;

  always_comb begin
    station = {sta_hi[HI_BYTES-1:0], sta_lo};
    is_bc   = &da;
    is_mc   = da[0] & ~is_bc;
    is_uc   = ~da[0];
    if (is_bc)      rule_ok = ~ctrl[CTRL_DISBC];
    else if (is_mc) rule_ok = ctrl[CTRL_ALLMC] | (ctrl[CTRL_HASH] & hash_hit);
    else            rule_ok = is_uc & (da == station);
    res.fail   = ~rule_ok;
    res.accept = rule_ok | ctrl[CTRL_PROMIS];
    res.mcast  = is_mc;
    res.bcast  = is_bc;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              da_valid,
  input  logic [ADDR_W-1:0] da,
  input  logic [WORD_W-1:0] sta_hi,
  input  logic [WORD_W-1:0] sta_lo,
  input  logic [WORD_W-1:0] hash_hi,
  input  logic [WORD_W-1:0] hash_lo,
  input  logic [WORD_W-1:0] ctrl,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_mcast,
  output logic              res_bcast,
  output logic              res_fail
);
  logic [HASH_W-1:0] hash_idx;
  logic              hash_hit;
  rxaf_result_t      dec, res_q, res_d;
  logic              vld_d, vld_q;

  rxaf_hash u_hash (
    .da(da), .tbl_hi(hash_hi), .tbl_lo(hash_lo), .idx(hash_idx), .hit(hash_hit)
  );

  rxaf_decide u_decide (
    .da(da), .sta_hi(sta_hi), .sta_lo(sta_lo), .ctrl(ctrl),
    .hash_hit(hash_hit), .res(dec)
  );

  always_comb begin
    vld_d = da_valid;
    res_d = da_valid ? dec : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (da_valid) res_q <= res_d;
    end
  end

  assign res_valid  = vld_q;
  assign res_accept = res_q.accept;
  assign res_mcast  = res_q.mcast;
  assign res_bcast  = res_q.bcast;
  assign res_fail   = res_q.fail;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> $stable({res_accept, res_mcast, res_bcast, res_fail}) && !res_valid);
  assert_unicast_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !da[0] && !ctrl[CTRL_PROMIS] && da != {sta_hi[15:0], sta_lo})
      |=> !res_accept && res_fail);
  assert_bcast_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && (&da) && ctrl[CTRL_DISBC] && !ctrl[CTRL_PROMIS]) |=> !res_accept);
  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_mcast, res_bcast}));
  assert_allmc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da[0] && !(&da) && ctrl[CTRL_ALLMC]) |=> res_accept && res_mcast);
  assert_promisc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && ctrl[CTRL_PROMIS]) |=> res_accept);
  assert_fail_inverse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !ctrl[CTRL_PROMIS]) |=> (res_accept != res_fail));
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic da_valid;
  logic [47:0] da;
  logic [31:0] sta_hi, sta_lo, hash_hi, hash_lo, ctrl;
  logic res_valid, res_accept, res_mcast, res_bcast, res_fail;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
    .sta_hi(sta_hi), .sta_lo(sta_lo), .hash_hi(hash_hi), .hash_lo(hash_lo),
    .ctrl(ctrl), .res_valid(res_valid), .res_accept(res_accept),
    .res_mcast(res_mcast), .res_bcast(res_bcast), .res_fail(res_fail)
  );

  // entry: {address, mode {promisc, allmc, hash, disbc}, expect {acc, mc, bc, fail}}
  localparam int NV = 12;
  localparam logic [55:0] VEC [NV] = '{
    {48'h554433221100, 4'h0, 4'b1000},
    {48'h554433221102, 4'h0, 4'b0001},
    {48'h564433221100, 4'h0, 4'b0001},
    {48'hFFFFFFFFFFFF, 4'h0, 4'b1010},
    {48'hFFFFFFFFFFFF, 4'h1, 4'b0011},
    {48'hFFFFFFFFFFFF, 4'h9, 4'b1011},
    {48'h00005E000001, 4'h0, 4'b0101},
    {48'h00005E000001, 4'h2, 4'b0101},
    {48'h00005E000001, 4'h4, 4'b1100},
    {48'h554433221102, 4'h8, 4'b1001},
    {48'hFFFFFFFFFFFF, 4'h5, 4'b0011},
    {48'h554433221100, 4'h6, 4'b1000}
  };

  function automatic string vec_req(int i);
    case (i)
      0, 1, 2:  return "R3 unicast";
      3, 4:     return "R4 broadcast";
      5:        return "R9 promiscuous over broadcast reject";
      6, 7:     return "R7 multicast reject";
      8:        return "R8 pass all multicast";
      9:        return "R10 fail under promiscuous";
      10:       return "R5 broadcast not multicast";
      default:  return "R3 match with multicast modes";
    endcase
  endfunction

  function automatic logic [31:0] mode_ctrl(input logic [3:0] m);
    return (32'(m[3]) << 18) | (32'(m[2]) << 19) | (32'(m[1]) << 13) | (32'(m[0]) << 11);
  endfunction

  // reflected CRC; its lowest six bits reversed give the index
  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] r;
    r = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      r = r ^ {24'h0, a[8*b +: 8]};
      for (int k = 0; k < 8; k++)
        r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,acc,mc,bc,fail} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {res_valid, res_accept, res_mcast, res_bcast, res_fail};
  endfunction

  task automatic apply(input logic [47:0] a, input logic [31:0] c);
    @(negedge clk);
    da = a; ctrl = c; da_valid = 1'b1;
    @(negedge clk);
    da_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] lo_addr, hi_addr;
    logic [5:0] lo_idx, hi_idx;
    bit got_lo, got_hi;
    rst_n = 1'b0; da_valid = 1'b0; da = '0; ctrl = '0;
    sta_hi = 32'h0000_5544; sta_lo = 32'h3322_1100;
    hash_hi = '0; hash_lo = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", outs(), 5'b00000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", outs(), 5'b00000);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][55:8], mode_ctrl(VEC[i][7:4]));
      chk(vec_req(i), outs(), {1'b1, VEC[i][3:0]});
    end

    // R2: hold without strobe, input changes ignored
    @(negedge clk);
    da = 48'hFFFFFFFFFFFF; ctrl = mode_ctrl(4'h1);
    @(negedge clk);
    chk("R2 hold", outs(), 5'b01000);

    // R2: back-to-back strobes
    @(negedge clk);
    da = 48'hFFFFFFFFFFFF; ctrl = mode_ctrl(4'h1); da_valid = 1'b1;
    @(negedge clk);
    da = 48'h554433221100; ctrl = 32'h0;
    chk("R2 first of pair", outs(), 5'b10011);
    @(negedge clk);
    da_valid = 1'b0;
    chk("R2 second of pair", outs(), 5'b11000);

    // R6/R7: hash bins on both table halves
    got_lo = 1'b0; got_hi = 1'b0; lo_addr = '0; hi_addr = '0; lo_idx = '0; hi_idx = '0;
    for (int k = 0; k < 64; k++) begin
      logic [47:0] cand;
      logic [5:0] ix;
      cand = {8'h01, 8'(k), 8'h5E, 8'h00, 8'(k * 3), 8'h01};
      ix = ref_index(cand);
      if (!ix[5] && !got_lo) begin got_lo = 1'b1; lo_addr = cand; lo_idx = ix; end
      if (ix[5] && !got_hi) begin got_hi = 1'b1; hi_addr = cand; hi_idx = ix; end
    end
    chk("R6 candidates found", {3'b0, got_lo, got_hi}, 5'b00011);

    hash_lo = 32'h1 << lo_idx[4:0]; hash_hi = '0;
    apply(lo_addr, mode_ctrl(4'h2));
    chk("R6 low word bin hit", outs(), 5'b11100);
    hash_lo = ~(32'h1 << lo_idx[4:0]); hash_hi = '1;
    apply(lo_addr, mode_ctrl(4'h2));
    chk("R7 low word bin clear", outs(), 5'b10101);

    hash_hi = 32'h1 << hi_idx[4:0]; hash_lo = '0;
    apply(hi_addr, mode_ctrl(4'h2));
    chk("R6 high word bin hit", outs(), 5'b11100);
    apply(hi_addr, mode_ctrl(4'h0));
    chk("R7 hash mode off", outs(), 5'b10101);
    hash_hi = ~(32'h1 << hi_idx[4:0]); hash_lo = '1;
    apply(hi_addr, mode_ctrl(4'h2));
    chk("R7 high word bin clear", outs(), 5'b10101);

    // R5/R6: broadcast never hashed even with full table
    hash_hi = '1; hash_lo = '1;
    apply(48'hFFFFFFFFFFFF, mode_ctrl(4'h3));
    chk("R5 broadcast with full hash table", outs(), 5'b10011);

    // R9: promiscuous with rejected multicast
    hash_hi = '0; hash_lo = '0;
    apply(hi_addr, mode_ctrl(4'hA));
    chk("R9 promiscuous multicast", outs(), 5'b11101);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule